// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register Bank

This block holds the per-channel 16-bit registers that sit next to a free-running 16-bit timer counter. The counter value arrives as an input. Each of the six channels has a mode bit. In capture mode, the channel register takes a snapshot of the counter whenever the channel's edge strobe fires. In compare mode, the register holds a value that software loads, and the channel raises a one-cycle match pulse when the counter reaches that value.

Software reaches the bank through an 8-bit, byte-addressed read/write port. A 16-bit value is moved as two bytes, high byte first. A high-byte read returns the live upper byte and freezes the lower byte in a shared read buffer. The low-byte read that follows returns that frozen byte, so both halves belong to the same instant. A high-byte write parks its byte in a shared write buffer. The low-byte write that follows commits all 16 bits in one clock.

The bank has room for eight channel slots, but only six channels exist. The two spare slots read as zero and ignore writes. The mode bits live in their own byte register at offset 0x00.

Top module: `tcc_bank`

## Requirements
- R1: After reset, every channel register, the mode register and both shared buffers are zero, and `match_o` is zero.
- R2: Channel n (0..5) has its high byte at offset 0x10+2n and its low byte at 0x11+2n. Offset 0x00 is the mode register, where bit n = 1 selects compare mode and 0 selects capture mode for channel n. Bits 6 and 7 of the mode register read as zero.
- R3: A read of any offset from 0x1C to 0x1F returns 0x00, as does a read of any unmapped offset. A write to 0x1C..0x1F changes nothing, and that includes the shared write buffer.
- R4: On a clock edge where channel n is in capture mode and `edge_i[n]` is 1, the channel register loads the value that `cnt_i` has at that edge. In compare mode, `edge_i[n]` has no effect.
- R5: While channel n is in capture mode, writes to its high and low offsets leave the channel register unchanged.
- R6: In compare mode, a high-byte write on its own leaves the channel register unchanged. A low-byte write then sets the register to {last high byte written to any channel, low byte} in one clock.
- R7: A high-byte read returns the channel's current upper byte and saves its lower byte in a single shared read buffer. Any low-byte channel read returns the saved byte, even if the channel has changed since the high-byte read.
- R8: `match_o[n]` is 1 for exactly the cycle after a clock edge at which channel n was in compare mode and `cnt_i` equalled its register. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| edge_i | input | 6 | Per-channel edge-detect strobes |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr_i | input | 8 | Byte offset within the bank |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, valid in the cycle `rd_en` is high |
| match_o | output | 6 | Per-channel compare match pulses |

## Verification
The bench attacks the coherence of the shared buffers in three ways:
- **Capture between byte reads.** A capture lands between a high-byte read and the matching low-byte read. A design that reads the low byte live would return a torn value.
- **Crossed channels.** A high-byte read or write on one channel is followed by the low-byte access on another, which shows that the buffer is shared.
- **Reserved-slot write.** A high-byte write to a reserved slot is followed by a commit. A design that lets the reserved write reach the write buffer would commit the wrong upper byte.

It also checks four mode-dependent cases:
- Writes in capture mode.
- Strobes in compare mode.
- The unused upper mode bits.
- A compare value placed just ahead of the counter, so that a missing, early or stretched match pulse shows up on the cycle-by-cycle comparison.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int BYTE_W = 8;
  localparam int CH_W   = 2 * BYTE_W;

  // True when byte offset a falls inside the channel window
  function automatic logic in_window(input int unsigned a, input int unsigned base,
                                     input int unsigned slots);
    return (a >= base) && (a < base + 2 * slots);
  endfunction

  // Channel slot addressed by byte offset a
  function automatic int unsigned slot_of(input int unsigned a, input int unsigned base);
    return (a - base) >> 1;
  endfunction

  // Even offsets carry the high byte
  function automatic logic is_high(input int unsigned a);
    return (a % 2) == 0;
  endfunction
endpackage

// File: rtl/tcc_chan.sv
module tcc_chan
  import tcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            cap_stb_i,
  input  logic [CH_W-1:0] cnt_i,
  input  logic            wr_stb_i,
  input  logic [CH_W-1:0] wr_val_i,
  output logic [CH_W-1:0] val_o,
  output logic            match_o,
  output logic            cap_fire_o,
  output logic            wr_fire_o
);
  // Capture wins over a software write on the same edge
  assign cap_fire_o = cap_stb_i & ~mode_i;
  assign wr_fire_o  = wr_stb_i & mode_i & ~cap_fire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o   <= '0;
      match_o <= 1'b0;
    end else begin
      if (cap_fire_o)
        val_o <= cnt_i;
      else if (wr_fire_o)
        val_o <= wr_val_i;
      match_o <= mode_i && (cnt_i == val_o);
    end
  end
endmodule

// File: rtl/tcc_regif.sv
module tcc_regif
  import tcc_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int NUM_SLOTS = 8,
  parameter int AW        = 8,
  parameter int BASE      = 16,
  parameter int MODE_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  input  logic [NUM_CH*CH_W-1:0] chan_flat_i,
  output logic [BYTE_W-1:0]      rdata_o,
  output logic [NUM_CH-1:0]      mode_o,
  output logic [NUM_CH-1:0]      commit_o,
  output logic [CH_W-1:0]        commit_val_o
);
  localparam logic [AW-1:0] MODE_A = AW'(MODE_ADDR);

  int unsigned       a_u;
  int unsigned       slot_n;
  logic              is_ch;
  logic              hi;
  logic [CH_W-1:0]   sel_val;
  logic [BYTE_W-1:0] rbuf_lo;
  logic [BYTE_W-1:0] wbuf_hi;
  logic [NUM_CH-1:0] mode_q;

  assign a_u    = 32'(addr_i);
  assign slot_n = slot_of(a_u, BASE);
  assign is_ch  = in_window(a_u, BASE, NUM_SLOTS) && (slot_n < NUM_CH);
  assign hi     = is_high(a_u);

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (slot_n == 32'(i)) sel_val = chan_flat_i[i*CH_W +: CH_W];
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      commit_o[i] = wr_en && is_ch && !hi && (slot_n == 32'(i));
  end
  assign commit_val_o = {wbuf_hi, wdata_i};
  assign mode_o       = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_lo <= '0;
      wbuf_hi <= '0;
      mode_q  <= '0;
    end else begin
      if (rd_en && is_ch && hi) rbuf_lo <= sel_val[BYTE_W-1:0];
      if (wr_en && is_ch && hi) wbuf_hi <= wdata_i;
      if (wr_en && addr_i == MODE_A) mode_q <= wdata_i[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (addr_i == MODE_A)
        rdata_o = BYTE_W'(mode_q);
      else if (is_ch)
        rdata_o = hi ? sel_val[CH_W-1:BYTE_W] : rbuf_lo;
    end
  end
endmodule

// File: rtl/tcc_bank.sv
module tcc_bank
  import tcc_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int NUM_SLOTS = 8,
  parameter int AW        = 8,
  parameter int BASE      = 16,
  parameter int MODE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   cnt_i,
  input  logic [NUM_CH-1:0] edge_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] match_o
);
  logic [NUM_CH-1:0]      mode_w;
  logic [NUM_CH-1:0]      commit_w;
  logic [CH_W-1:0]        commit_val;
  logic [NUM_CH*CH_W-1:0] chan_flat;
  logic [NUM_CH-1:0]      cap_fire;
  logic [NUM_CH-1:0]      wr_fire;

  tcc_regif #(
    .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .AW(AW), .BASE(BASE), .MODE_ADDR(MODE_ADDR)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_i(addr_i),
    .wdata_i(wdata_i), .chan_flat_i(chan_flat), .rdata_o(rdata_o), .mode_o(mode_w),
    .commit_o(commit_w), .commit_val_o(commit_val)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tcc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_w[g]), .cap_stb_i(edge_i[g]),
      .cnt_i(cnt_i), .wr_stb_i(commit_w[g]), .wr_val_i(commit_val),
      .val_o(chan_flat[g*CH_W +: CH_W]), .match_o(match_o[g]),
      .cap_fire_o(cap_fire[g]), .wr_fire_o(wr_fire[g])
    );
  end
endmodule

// File: rtl/tcc_bank_chk.sv
module tcc_bank_chk
  import tcc_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int NUM_SLOTS = 8,
  parameter int AW        = 8,
  parameter int BASE      = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CH_W-1:0]        cnt_i,
  input logic [NUM_CH-1:0]      edge_i,
  input logic                   rd_en,
  input logic [AW-1:0]          addr_i,
  input logic [BYTE_W-1:0]      rdata_o,
  input logic [NUM_CH-1:0]      match_o,
  input logic [NUM_CH-1:0]      mode_w,
  input logic [NUM_CH*CH_W-1:0] chan_flat,
  input logic [NUM_CH-1:0]      cap_fire
);
  localparam logic [AW-1:0] RSV_LO = AW'(BASE + 2 * NUM_CH);
  localparam logic [AW-1:0] RSV_HI = AW'(BASE + 2 * NUM_SLOTS - 1);

  always @(posedge clk) begin
    if (!rst_n) assert_rst_match_R1: assert (match_o == '0);
  end

  assert_rsv_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr_i >= RSV_LO && addr_i <= RSV_HI) |-> rdata_o == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    assert_cap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire[g] |=> chan_flat[g*CH_W +: CH_W] == $past(cnt_i));
    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_w[g] && !edge_i[g]) |=> $stable(chan_flat[g*CH_W +: CH_W]));
    assert_match_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match_o[g] |-> $past(mode_w[g]));
  end
endmodule

bind tcc_bank tcc_bank_chk #(
  .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .AW(AW), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .edge_i(edge_i), .rd_en(rd_en),
  .addr_i(addr_i), .rdata_o(rdata_o), .match_o(match_o), .mode_w(mode_w),
  .chan_flat(chan_flat), .cap_fire(cap_fire)
);

// File: tb/tb_tcc_bank.sv
module tb_tcc_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = 16'h0100;
  logic [5:0]  edge_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr_i = '0, wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [5:0]  match_o;

  tcc_bank dut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference state
  int    m_chan [6];
  int    m_mode, m_rbuf, m_wbuf;
  bit    m_match [6];
  int    match_seen;
  int    checks, errors;
  bit    done;
  string tag = "R1";

  always @(negedge clk) if (rst_n) cnt_i <= cnt_i + 16'd1;

  function automatic int exp_rd(input int a);
    if (a == 0) return m_mode;
    if (a >= 16 && a < 28) begin
      if (a % 2 == 0) return (m_chan[(a - 16) / 2] >> 8) & 255;
      return m_rbuf;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_chan[i]) begin m_chan[i] = 0; m_match[i] = 0; end
      m_mode = 0; m_rbuf = 0; m_wbuf = 0;
    end else begin
      int a, n, nmode, nwbuf, nrbuf;
      int nchan [6];
      a = int'(addr_i); n = (a - 16) / 2;
      nmode = m_mode; nwbuf = m_wbuf; nrbuf = m_rbuf;
      foreach (m_chan[i]) begin
        nchan[i] = m_chan[i];
        m_match[i] = m_mode[i] && (int'(cnt_i) == m_chan[i]);
        if (m_match[i]) match_seen++;
        if (edge_i[i] && !m_mode[i]) nchan[i] = int'(cnt_i);
      end
      if (rd_en && a >= 16 && a < 28 && a % 2 == 0) nrbuf = m_chan[n] & 255;
      if (wr_en && a == 0) nmode = int'(wdata_i) & 63;
      if (wr_en && a >= 16 && a < 28) begin
        if (a % 2 == 0) nwbuf = int'(wdata_i);
        else if (m_mode[n]) nchan[n] = (m_wbuf << 8) | int'(wdata_i);
      end
      foreach (m_chan[i]) m_chan[i] = nchan[i];
      m_mode = nmode; m_wbuf = nwbuf; m_rbuf = nrbuf;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int i = 0; i < 6; i++) begin
        checks++;
        if (match_o[i] !== m_match[i]) begin
          errors++;
          $display("FAIL R8 match ch%0d actual %0b expected %0b", i, match_o[i], m_match[i]);
        end
      end
      if (rd_en) begin
        checks++;
        if (int'(rdata_o) != exp_rd(int'(addr_i))) begin
          errors++;
          $display("FAIL %s read @%02h actual %02h expected %02h", tag, addr_i, rdata_o,
                   exp_rd(int'(addr_i)));
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr_i = 8'(a); wdata_i = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input int a);
    @(negedge clk); rd_en = 1'b1; addr_i = 8'(a);
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic strobe(input int n);
    @(negedge clk); edge_i[n] = 1'b1;
    @(negedge clk); edge_i = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: everything reads zero after reset
    tag = "R1";
    checks++;
    if (match_o !== 6'h0) begin errors++; $display("FAIL R1 match actual %h expected 0", match_o); end
    rd(0);
    for (int a = 16; a < 32; a++) rd(a);
    // R2: mode register width, channel addressing
    tag = "R2";
    wr(0, 255); rd(0);
    for (int n = 0; n < 6; n++) begin
      wr(16 + 2 * n, 160 + n); wr(17 + 2 * n, 80 + n);
      rd(16 + 2 * n); rd(17 + 2 * n);
    end
    // R8: compare value just ahead of the counter
    tag = "R8";
    wr(20, int'(cnt_i + 16'd20) >> 8); wr(21, int'(cnt_i + 16'd18) & 255);
    idle(40);
    // R5: writes ignored in capture mode (ch0, ch1 capture)
    tag = "R5";
    wr(0, 60);
    wr(16, 17); wr(17, 34); rd(16); rd(17);
    // R4: captures, and a strobe on a compare channel
    tag = "R4";
    strobe(0); rd(16); rd(17);
    strobe(1); rd(18); rd(19);
    strobe(3); rd(22); rd(23);
    // R7: capture between halves, crossed channels
    tag = "R7";
    rd(18); strobe(1); rd(19); rd(18); rd(19);
    rd(16); rd(19);
    // R6: high alone has no effect, low commits
    tag = "R6";
    wr(24, 119); rd(24); rd(25);
    wr(25, 136); rd(24); rd(25);
    wr(22, 18); wr(27, 52); rd(26); rd(27);
    // R3: reserved slots
    tag = "R3";
    wr(24, 3); wr(28, 171); wr(29, 205); wr(30, 1); wr(31, 2);
    wr(25, 68); rd(24); rd(25);
    for (int a = 28; a < 32; a++) rd(a);
    rd(32); rd(5);
    idle(3);
    checks++;
    if (match_seen == 0) begin errors++; $display("FAIL R8 match events actual 0 expected >0"); end
    done = 1'b1;
    summary();
  end
endmodule